// File: doc/BRIEF.md
# Ethernet PHY Management Master

This block runs the two-wire station management link between a MAC-side controller and one Ethernet PHY. It produces the management clock from the system clock through a programmable half-period divider and shifts out framed register transactions on the data line: a 32-bit preamble, start and opcode, PHY and register addresses, turnaround, and 16 data bits. The data line leaves the block as three pins: a value, an output enable, and an input. This lets a pad or a test bench resolve the line as a tri-state wire.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` is ignored and nothing is queued, so a requester that must not lose a command holds `req_valid` until it sees `req_ready`. Completion is a single-cycle `done` pulse, which has no back-pressure. Besides raw register reads and writes, the block has three built-in operations. A soft reset writes the reset word to the control register and then stays busy for a programmable wait. A link-mode request writes the control register from a 3-bit mode code. A link query reads the status register and raises a link flag.

Top module: `mdio_mgmt`

## Requirements
- R1: Every frame begins with 32 MDC cycles in which MDIO is 1. MDC rests low whenever no frame is in progress, and MDIO is driven to 1 while idle.
- R2: After the preamble, the block sends 0110 for a read or 0101 for a write. It then sends the PHY address (parameter `PHY_ADDR`, default 7) and the 5-bit register address. All fields go out MSB first.
- R3: A write frame drives turnaround bits 1 then 0, then the 16 data bits MSB first. It ends with one MDC cycle with MDIO driven to 1, for 65 MDC cycles in total.
- R4: In a read frame, `mdio_oe` is low for exactly the 2 turnaround and 16 data cycles and high at every other time. Each data bit is sampled at the end of its MDC low phase, MSB first, and the result appears on `rd_data`. The master drives the line again for the final idle cycle.
- R5: The MDC high and low phases each last `div_half` system clocks, and a value of 0 acts as 1. MDIO changes only while MDC is low. `done` is seen 130·H+2 clocks after the request is presented on a falling clock edge, where H is the effective half period.
- R6: `req_ready` equals not-busy. A request presented while `req_ready` is low produces no frame and alters no result. `done` is high for exactly one cycle and coincides with `req_ready` rising.
- R7: `req_op`=2 (soft reset) writes 0x8000 to register 0. After the frame, the block stays busy for exactly `rst_wait` further clocks before `done`.
- R8: `req_op`=3 with `req_mode[2]`=0 writes 0x1000 to register 0, which sets only the auto-negotiation enable bit 12.
- R9: `req_op`=3 with `req_mode[2]`=1 writes register 0 with bit 13 = `req_mode[1]` (1 = 100 Mbit/s) and bit 8 = `req_mode[0]` (1 = full duplex). All other bits are 0.
- R10: `req_op`=4 reads register 1. `link_up` takes bit 2 of the returned word, and `rd_data` holds the whole word.
- R11: `req_op`=0 is a raw read of `req_reg` and `req_op`=1 a raw write of `req_wdata`. Codes 5 to 7 act as a raw read. `rd_data` and `link_up` change only when a read-type operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_half | input | DIV_W | MDC half period in system clocks (0 acts as 1), held steady during a frame |
| rst_wait | input | WAIT_W | Busy hold after a soft-reset frame, in clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken when valid and ready |
| req_op | input | 3 | 0 read, 1 write, 2 soft reset, 3 link mode, 4 link query |
| req_reg | input | 5 | Register address for raw operations |
| req_wdata | input | 16 | Write data for raw write |
| req_mode | input | 3 | Bit 2 fixed mode, bit 1 100 Mbit/s, bit 0 full duplex |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| link_up | output | 1 | Link flag from the last link query |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
A slot counter that is off by one moves every field after the fault by one MDC cycle. The PHY model then decodes the wrong opcode or address at the first rising edge past the fault, and the frame check at `done` reports it. An MDC divider fault shows in the first measured high or low phase and in the `done` latency of that same request. A faulty turnaround window shows as a line contention or an enable check at the first turnaround rising edge. A wrong operation decode shows as a wrong register word in the captured frame, or as a stale `rd_data` or `link_up` immediately after `done`.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_SOFTRST  = 3'd2,
    OP_LINKMODE = 3'd3,
    OP_LINKQ    = 3'd4
  } mgmt_op_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_FRAME,
    CT_HOLD
  } ctrl_state_e;

  typedef struct packed {
    logic        rd;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } frame_req_t;

  // slot layout of one frame (one slot = one MDC period)
  localparam int PRE_SLOTS  = 32;
  localparam int TA_SLOT    = 46;
  localparam int DATA_SLOT  = 48;
  localparam int LAST_DATA  = 63;
  localparam int IDLE_SLOT  = 64;
  localparam int SLOT_W     = 7;

  localparam logic [4:0]  REG_CONTROL = 5'd0;
  localparam logic [4:0]  REG_STATUS  = 5'd1;
  localparam logic [15:0] WORD_RESET  = 16'h8000;
  localparam logic [15:0] WORD_AUTONEG = 16'h1000;
  localparam int          LINK_BIT    = 2;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             edge_now;

  assign lim      = (half == '0) ? '0 : half - DIV_W'(1);
  assign edge_now = run && (cnt >= lim);
  assign rise_tk  = edge_now && !mdc;
  assign fall_tk  = edge_now && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R1: the clock parks low outside a frame
  p_mdc_parks_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

  // R5: a rising MDC edge only comes from a running frame
  p_rise_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(run));

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  frame_req_t  freq,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        run,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        fdone,
  output logic [15:0] rd_word
);
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_nx;
  logic [31:0]       hdr;
  logic              is_rd;
  logic [15:0]       shreg;

  function automatic logic bit_of(input logic [SLOT_W-1:0] s, input logic [31:0] h);
    logic [SLOT_W-1:0] idx;
    idx = SLOT_W'(LAST_DATA) - s;
    if (s < SLOT_W'(PRE_SLOTS) || s >= SLOT_W'(IDLE_SLOT)) return 1'b1;
    return h[idx[4:0]];
  endfunction

  function automatic logic oe_of(input logic [SLOT_W-1:0] s, input logic rd);
    return !(rd && s >= SLOT_W'(TA_SLOT) && s <= SLOT_W'(LAST_DATA));
  endfunction

  assign slot_nx = slot + SLOT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      slot    <= '0;
      hdr     <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
      fdone   <= 1'b0;
      shreg   <= '0;
      rd_word <= '0;
    end else begin
      fdone <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          slot    <= '0;
          is_rd   <= freq.rd;
          hdr     <= {freq.rd ? 4'b0110 : 4'b0101, PHY_ADDR, freq.regad,
                      freq.rd ? 2'b11 : 2'b10, freq.rd ? 16'hFFFF : freq.wdata};
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end else begin
        if (rise_tk && is_rd && slot >= SLOT_W'(DATA_SLOT) && slot <= SLOT_W'(LAST_DATA))
          shreg <= {shreg[14:0], mdio_i};
        if (fall_tk) begin
          if (slot == SLOT_W'(IDLE_SLOT)) begin
            run     <= 1'b0;
            fdone   <= 1'b1;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
            if (is_rd) rd_word <= shreg;
          end else begin
            slot    <= slot_nx;
            mdio_o  <= bit_of(slot_nx, hdr);
            mdio_oe <= oe_of(slot_nx, is_rd);
          end
        end
      end
    end
  end

  // R4: the line is released only inside a read frame
  p_release_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> (run && is_rd));

  // R1: preamble slots drive ones
  p_preamble_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slot < SLOT_W'(PRE_SLOTS)) |-> (mdio_o && mdio_oe));

  // R6: completion strobe lasts one cycle
  p_fdone_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fdone |=> !fdone);

endmodule

// File: rtl/mdio_op_ctrl.sv
module mdio_op_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int WAIT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [4:0]        req_reg,
  input  logic [15:0]       req_wdata,
  input  logic [2:0]        req_mode,
  input  logic [WAIT_W-1:0] rst_wait,
  input  logic              fdone,
  input  logic [15:0]       rd_word,
  output logic              req_ready,
  output logic              start,
  output frame_req_t        freq,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              link_up
);
  ctrl_state_e       state;
  mgmt_op_e          op_q;
  mgmt_op_e          op_eff;
  logic [WAIT_W-1:0] wcnt;
  logic              op_reads;

  assign req_ready = (state == CT_IDLE);
  assign start     = req_valid && req_ready;
  assign op_reads  = (op_q == OP_READ) || (op_q == OP_LINKQ);

  always_comb begin
    op_eff     = OP_READ;
    freq.rd    = 1'b1;
    freq.regad = req_reg;
    freq.wdata = '0;
    case (req_op)
      OP_WRITE: begin
        op_eff     = OP_WRITE;
        freq.rd    = 1'b0;
        freq.wdata = req_wdata;
      end
      OP_SOFTRST: begin
        op_eff     = OP_SOFTRST;
        freq.rd    = 1'b0;
        freq.regad = REG_CONTROL;
        freq.wdata = WORD_RESET;
      end
      OP_LINKMODE: begin
        op_eff     = OP_LINKMODE;
        freq.rd    = 1'b0;
        freq.regad = REG_CONTROL;
        freq.wdata = req_mode[2] ? {2'b00, req_mode[1], 4'b0000, req_mode[0], 8'h00}
                                 : WORD_AUTONEG;
      end
      OP_LINKQ: begin
        op_eff     = OP_LINKQ;
        freq.regad = REG_STATUS;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CT_IDLE;
      op_q    <= OP_READ;
      wcnt    <= '0;
      done    <= 1'b0;
      rd_data <= '0;
      link_up <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        CT_IDLE: begin
          if (start) begin
            op_q  <= op_eff;
            state <= CT_FRAME;
          end
        end
        CT_FRAME: begin
          if (fdone) begin
            if (op_q == OP_SOFTRST && rst_wait != '0) begin
              state <= CT_HOLD;
              wcnt  <= '0;
            end else begin
              state <= CT_IDLE;
              done  <= 1'b1;
              if (op_reads) rd_data <= rd_word;
              if (op_q == OP_LINKQ) link_up <= rd_word[LINK_BIT];
            end
          end
        end
        CT_HOLD: begin
          if (wcnt >= rst_wait - WAIT_W'(1)) begin
            state <= CT_IDLE;
            done  <= 1'b1;
          end else begin
            wcnt <= wcnt + WAIT_W'(1);
          end
        end
        default: state <= CT_IDLE;
      endcase
    end
  end

  // R6: a request offered while busy leaves the captured operation alone
  p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(op_q));

  // R6: completion coincides with readiness
  p_done_with_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R7: the hold state belongs to a soft reset
  p_hold_is_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CT_HOLD) |-> (op_q == OP_SOFTRST));

  // R10: the link flag moves only at the end of a link query
  p_link_from_query_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_up) |-> (done && op_q == OP_LINKQ));

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd7,
  parameter int         DIV_W    = 8,
  parameter int         WAIT_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [WAIT_W-1:0] rst_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [4:0]        req_reg,
  input  logic [15:0]       req_wdata,
  input  logic [2:0]        req_mode,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              link_up,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        start;
  frame_req_t  freq;
  logic        run;
  logic        rise_tk;
  logic        fall_tk;
  logic        fdone;
  logic [15:0] rd_word;

  mdio_op_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .req_mode  (req_mode),
    .rst_wait  (rst_wait),
    .fdone     (fdone),
    .rd_word   (rd_word),
    .req_ready (req_ready),
    .start     (start),
    .freq      (freq),
    .done      (done),
    .rd_data   (rd_data),
    .link_up   (link_up)
  );

  mdio_frame_eng #(.PHY_ADDR(PHY_ADDR)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .freq    (freq),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk),
    .mdio_i  (mdio_i),
    .run     (run),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .fdone   (fdone),
    .rd_word (rd_word)
  );

  mdio_mdc_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half    (div_half),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  // R5: driven data only changes while the clock is low
  p_launch_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);

  // R1: idle line is driven high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mdio_oe && mdio_o && !mdc));

endmodule

// File: tb/sim_mdio_mgmt.sv
module sim_mdio_mgmt;
  localparam int DIV_W  = 8;
  localparam int WAIT_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  div_half;
  logic [WAIT_W-1:0] rst_wait;
  logic              req_valid;
  logic              req_ready;
  logic [2:0]        req_op;
  logic [4:0]        req_reg;
  logic [15:0]       req_wdata;
  logic [2:0]        req_mode;
  logic              done;
  logic [15:0]       rd_data;
  logic              link_up;
  logic              mdc;
  logic              mdio_o;
  logic              mdio_oe;
  logic              phy_o = 1'b1;
  logic              phy_oe = 1'b0;
  logic              mline;

  always #5 clk = ~clk;

  assign mline = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_mgmt u0 (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .rst_wait(rst_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_mode(req_mode),
    .done(done), .rd_data(rd_data), .link_up(link_up),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mline)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [15:0] phy_mem [32];

  // PHY model state
  int          rcnt = 0;
  int          runlen = 0;
  logic        mdc_d = 1'b0;
  logic        mdo_d = 1'b1;
  logic [3:0]  c_op;
  logic [4:0]  c_phy, c_reg;
  logic [1:0]  c_ta;
  logic [15:0] c_data;
  bit          pre_bad, idle_bad, oe_bad, tim_bad, clash;
  logic [3:0]  s_op;
  logic [4:0]  s_phy, s_reg;
  logic [1:0]  s_ta;
  logic [15:0] s_data;
  bit          s_pre, s_idle, s_oe, s_tim, s_clash;
  int          frames = 0;
  int          hexp;

  assign hexp = (div_half == '0) ? 1 : int'(div_half);

  always @(negedge clk) begin
    if (!rst_n) begin
      rcnt = 0; runlen = 0; mdc_d = 1'b0; mdo_d = 1'b1;
      phy_oe = 1'b0; phy_o = 1'b1;
      pre_bad = 0; idle_bad = 0; oe_bad = 0; tim_bad = 0; clash = 0;
    end else begin
      if (mdio_oe && phy_oe) clash = 1;
      if (mdc && mdc_d && mdio_oe && mdio_o !== mdo_d) tim_bad = 1;
      if (mdc != mdc_d) begin
        if (mdc_d || rcnt > 0) begin
          if (runlen != hexp) tim_bad = 1;
        end
        runlen = 1;
      end else begin
        runlen++;
      end
      if (mdc && !mdc_d) begin
        if (rcnt < 32) begin
          if (!mline) pre_bad = 1;
        end else if (rcnt < 36) c_op = {c_op[2:0], mline};
        else if (rcnt < 41) c_phy = {c_phy[3:0], mline};
        else if (rcnt < 46) c_reg = {c_reg[3:0], mline};
        else if (rcnt < 64) begin
          if (c_op == 4'b0110) begin
            if (mdio_oe) oe_bad = 1;
            if (rcnt == 46) begin phy_oe = 1'b1; phy_o = 1'b0; end
            else if (rcnt < 63) phy_o = phy_mem[c_reg][62-rcnt];
            else phy_oe = 1'b0;
          end else begin
            if (!mdio_oe) oe_bad = 1;
            if (rcnt < 48) c_ta = {c_ta[0], mline};
            else c_data = {c_data[14:0], mline};
          end
        end else begin
          if (!mline || !mdio_oe) idle_bad = 1;
          s_op = c_op; s_phy = c_phy; s_reg = c_reg; s_ta = c_ta; s_data = c_data;
          s_pre = pre_bad; s_idle = idle_bad; s_oe = oe_bad; s_tim = tim_bad; s_clash = clash;
          pre_bad = 0; idle_bad = 0; oe_bad = 0; tim_bad = 0; clash = 0;
          frames++;
          rcnt = -1;
        end
        rcnt++;
      end
      mdc_d = mdc;
      mdo_d = mdio_o;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [4:0] rg, input logic [15:0] wd,
                        input logic [2:0] md, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_reg = rg; req_wdata = wd; req_mode = md; req_valid = 1'b1;
    lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_frame(input string tag, input bit rd, input logic [4:0] rg,
                             input logic [15:0] wd);
    check(s_op == (rd ? 4'b0110 : 4'b0101), {tag, " R2 opcode"}, int'(s_op), rd ? 6 : 5);
    check(s_phy == 5'd7, {tag, " R2 phy address"}, int'(s_phy), 7);
    check(s_reg == rg, {tag, " R2 register address"}, int'(s_reg), int'(rg));
    check(!s_pre && !s_idle, {tag, " R1 R3 preamble/idle ones"}, int'({s_pre, s_idle}), 0);
    check(!s_oe && !s_clash, {tag, " R4 line ownership"}, int'({s_oe, s_clash}), 0);
    check(!s_tim, {tag, " R5 MDC phases and launch"}, int'(s_tim), 0);
    if (!rd) begin
      check(s_ta == 2'b10, {tag, " R3 turnaround"}, int'(s_ta), 2);
      check(s_data == wd, {tag, " R3 write data"}, int'(s_data), int'(wd));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    int base;
    int hl [5];
    logic [15:0] last_rd;
    logic [15:0] expw;
    hl = '{0, 1, 2, 3, 5};
    div_half = 8'd1; rst_wait = '0; req_valid = 1'b0;
    req_op = '0; req_reg = '0; req_wdata = '0; req_mode = '0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done, "R6 reset ready, no done", int'({req_ready, done}), 2);
    check(!mdc && mdio_oe && mdio_o, "R1 idle line after reset", int'({mdc, mdio_oe, mdio_o}), 3);
    check(rd_data == 16'h0 && !link_up, "R11 reset results", int'(rd_data), 0);
    last_rd = 16'h0;

    for (int i = 0; i < 5; i++) begin
      div_half = 8'(hl[i]);
      base = 130 * ((hl[i] == 0) ? 1 : hl[i]) + 2;
      // raw writes (R2, R3, R5, R11)
      for (int k = 0; k < 3; k++) begin
        logic [4:0] rg;
        logic [15:0] wd;
        rg = 5'((k * 13 + 2 + i) % 32);
        wd = 16'hA5C3 ^ 16'(k * 16'h1111) ^ 16'(i << 12);
        run_op(3'd1, rg, wd, 3'd0, lat);
        check(lat == base, "R5 write latency", lat, base);
        check_frame("raw write", 1'b0, rg, wd);
        check(rd_data == last_rd, "R11 rd_data kept over write", int'(rd_data), int'(last_rd));
      end
      // raw reads (R4, R11), including undefined opcode 6
      for (int k = 0; k < 3; k++) begin
        logic [4:0] rg;
        rg = 5'(k * 11 + 3 + i);
        phy_mem[rg] = 16'(16'h1234 * (k + 1) + i * 16'h0F01);
        run_op((k == 2) ? 3'd6 : 3'd0, rg, 16'h0, 3'd0, lat);
        check(lat == base, "R5 read latency", lat, base);
        check_frame("raw read", 1'b1, rg, 16'h0);
        check(rd_data == phy_mem[rg], "R4 R11 read data", int'(rd_data), int'(phy_mem[rg]));
        last_rd = phy_mem[rg];
      end
      // every link-mode code (R8, R9)
      for (int m = 0; m < 8; m++) begin
        logic [2:0] md;
        md = 3'(m);
        expw = md[2] ? ((16'(md[1]) << 13) | (16'(md[0]) << 8)) : 16'h1000;
        run_op(3'd3, 5'd0, 16'h0, md, lat);
        check_frame(md[2] ? "R9 fixed mode" : "R8 auto mode", 1'b0, 5'd0, expw);
        check(rd_data == last_rd, "R11 rd_data kept over mode", int'(rd_data), int'(last_rd));
      end
      // link query (R10)
      for (int v = 0; v < 2; v++) begin
        phy_mem[1] = (16'h5A5A ^ 16'(i)) & ~16'h0004 | 16'(v << 2);
        run_op(3'd4, 5'd9, 16'h0, 3'd0, lat);
        check_frame("R10 link query", 1'b1, 5'd1, 16'h0);
        check(link_up == v[0], "R10 link flag", int'(link_up), v);
        check(rd_data == phy_mem[1], "R10 status word", int'(rd_data), int'(phy_mem[1]));
        last_rd = phy_mem[1];
      end
      // soft reset with hold (R7)
      rst_wait = 24'(3 + i * 7);
      run_op(3'd2, 5'd17, 16'h1234, 3'd0, lat);
      check(lat == base + int'(rst_wait), "R7 reset hold", lat, base + int'(rst_wait));
      check_frame("R7 reset word", 1'b0, 5'd0, 16'h8000);
      rst_wait = '0;
      run_op(3'd2, 5'd0, 16'h0, 3'd0, lat);
      check(lat == base, "R7 reset with zero hold", lat, base);
    end

    // requests while busy are ignored (R6)
    begin
      int f0;
      div_half = 8'd2;
      f0 = frames;
      @(negedge clk);
      req_op = 3'd1; req_reg = 5'd9; req_wdata = 16'h0F0F; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (30) @(negedge clk);
      req_op = 3'd0; req_reg = 5'd3; req_valid = 1'b1;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      check(req_ready, "R6 ready with done", int'(req_ready), 1);
      @(negedge clk);
      check(!done, "R6 done single cycle", int'(done), 0);
      repeat (20) @(negedge clk);
      check(frames == f0 + 1, "R6 busy request dropped", frames - f0, 1);
      check_frame("R6 first request kept", 1'b0, 5'd9, 16'h0F0F);
      check(rd_data == last_rd, "R6 R11 result untouched", int'(rd_data), int'(last_rd));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule